// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a parameterised integer arithmetic and logic unit assembled from identical one-bit cells. Each cell holds a full adder, the bitwise paths and a small selector. A ripple carry chain links the cells. A decoder turns a 4-bit operation code into control signals for the cells: the operand-B invert, the carry-in and the path select. A final stage chooses between the slice outputs, a single comparison bit, or zero, and it gates the carry and overflow flags by operation.

The combinational core sits behind one output register. Inputs presented before a rising clock edge appear on the outputs just after that edge. A datapath stage drives two operands and a code every cycle and takes the result one cycle later. The default operand width is 32 bits.

Top module: `slice_alu`

## Requirements
- R1: A synchronous active-high reset clears result, carry and overflow to zero. Otherwise each output shows the function of the inputs sampled at the previous rising edge, so the latency is one cycle.
- R2: Code 0 (signed add) gives A+B modulo 2^WIDTH. Carry is the carry out of the top bit. Overflow is the carry into the top bit XOR the carry out of it, which is set when both operands share a sign that the sum lacks.
- R3: Code 1 (unsigned add) gives the same sum and carry as code 0, and overflow stays 0.
- R4: Code 2 (signed subtract) forms A + ~B + 1. It gives A-B modulo 2^WIDTH, with carry set when A >= B unsigned. Overflow is set when A and B differ in sign and the difference differs in sign from A.
- R5: Code 3 (unsigned subtract) gives the same difference and carry as code 2, and overflow stays 0.
- R6: Codes 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR of A and B.
- R7: Code 10 (signed compare) puts 1 in result bit 0 when A < B as two's complement numbers, and 0 otherwise. Bits WIDTH-1 to 1 are 0. This holds when A-B overflows.
- R8: Code 11 (unsigned compare) puts 1 in result bit 0 when A < B as unsigned numbers, with bits WIDTH-1 to 1 at 0.
- R9: Codes 8, 9, 12, 13, 14 and 15 give a zero result with carry and overflow at 0.
- R10: For every code of 4 or above, carry and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_code | input | 4 | Operation select |
| result | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered carry out of the top slice |
| ovf_flag | output | 1 | Registered signed overflow |

## Verification
The hardest case to reach from the ports is a signed compare where the subtraction overflows. In that case the sign of the raw difference gives the wrong answer, and only the overflow correction yields the right one. Random operands seldom hit it with the needed sign mix. The stimulus therefore drives directed pairs such as the most negative value against the most positive value, and the reverse, under both compare codes. It also drives the same pairs through signed subtract, so the overflow that the compare hides internally can be seen on the flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_ADD  = 4'd0,
    MD_ADDU = 4'd1,
    MD_SUB  = 4'd2,
    MD_SUBU = 4'd3,
    MD_AND  = 4'd4,
    MD_OR   = 4'd5,
    MD_XOR  = 4'd6,
    MD_NOR  = 4'd7,
    MD_SLT  = 4'd10,
    MD_SLTU = 4'd11
  } alu_mode_e;

  typedef enum logic [2:0] {
    SL_SUM,
    SL_AND,
    SL_OR,
    SL_XOR,
    SL_NOR
  } slice_sel_e;

  typedef enum logic [1:0] {
    SRC_SLICE,
    SRC_CMP,
    SRC_ZERO
  } out_src_e;

  typedef struct packed {
    slice_sel_e sel;
    logic       inv_b;
    logic       cin;
    out_src_e   src;
    logic       cmp_signed;
    logic       carry_en;
    logic       ovf_en;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_b_i,
  input  logic       cin_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o
);

  logic bx;
  logic half;

  assign bx     = b_i ^ inv_b_i;
  assign half   = a_i ^ bx;
  assign cout_o = (a_i & bx) | (cin_i & half);

  always_comb begin
    case (sel_i)
      SL_SUM:  res_o = half ^ cin_i;
      SL_AND:  res_o = a_i & b_i;
      SL_OR:   res_o = a_i | b_i;
      SL_XOR:  res_o = a_i ^ b_i;
      SL_NOR:  res_o = ~(a_i | b_i);
      default: res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output alu_ctrl_t         ctrl_o
);

  always_comb begin
    ctrl_o            = '0;
    ctrl_o.sel        = SL_SUM;
    ctrl_o.src        = SRC_ZERO;
    case (mode_i)
      MD_ADD: begin
        ctrl_o.src      = SRC_SLICE;
        ctrl_o.carry_en = 1'b1;
        ctrl_o.ovf_en   = 1'b1;
      end
      MD_ADDU: begin
        ctrl_o.src      = SRC_SLICE;
        ctrl_o.carry_en = 1'b1;
      end
      MD_SUB: begin
        ctrl_o.src      = SRC_SLICE;
        ctrl_o.inv_b    = 1'b1;
        ctrl_o.cin      = 1'b1;
        ctrl_o.carry_en = 1'b1;
        ctrl_o.ovf_en   = 1'b1;
      end
      MD_SUBU: begin
        ctrl_o.src      = SRC_SLICE;
        ctrl_o.inv_b    = 1'b1;
        ctrl_o.cin      = 1'b1;
        ctrl_o.carry_en = 1'b1;
      end
      MD_AND: begin
        ctrl_o.src = SRC_SLICE;
        ctrl_o.sel = SL_AND;
      end
      MD_OR: begin
        ctrl_o.src = SRC_SLICE;
        ctrl_o.sel = SL_OR;
      end
      MD_XOR: begin
        ctrl_o.src = SRC_SLICE;
        ctrl_o.sel = SL_XOR;
      end
      MD_NOR: begin
        ctrl_o.src = SRC_SLICE;
        ctrl_o.sel = SL_NOR;
      end
      MD_SLT: begin
        ctrl_o.src        = SRC_CMP;
        ctrl_o.inv_b      = 1'b1;
        ctrl_o.cin        = 1'b1;
        ctrl_o.cmp_signed = 1'b1;
      end
      MD_SLTU: begin
        ctrl_o.src   = SRC_CMP;
        ctrl_o.inv_b = 1'b1;
        ctrl_o.cin   = 1'b1;
      end
      default: ctrl_o.src = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_ctrl_t        ctrl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] slice_res;
  logic             ovf_raw;
  logic             less;

  assign chain[0] = ctrl_i.cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .inv_b_i (ctrl_i.inv_b),
      .cin_i   (chain[i]),
      .sel_i   (ctrl_i.sel),
      .res_o   (slice_res[i]),
      .cout_o  (chain[i+1])
    );
  end

  assign ovf_raw = chain[WIDTH] ^ chain[MSB];
  assign less    = ctrl_i.cmp_signed ? (slice_res[MSB] ^ ovf_raw) : ~chain[WIDTH];

  always_comb begin
    case (ctrl_i.src)
      SRC_SLICE: res_o = slice_res;
      SRC_CMP:   res_o = {{(WIDTH-1){1'b0}}, less};
      default:   res_o = '0;
    endcase
  end

  assign carry_o = ctrl_i.carry_en & chain[WIDTH];
  assign ovf_o   = ctrl_i.ovf_en & ovf_raw;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  input  logic [MODE_W-1:0] op_code,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out,
  output logic              ovf_flag
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] res_d;
  logic             carry_d;
  logic             ovf_d;

  alu_decode u_decode (
    .mode_i (op_code),
    .ctrl_o (ctrl)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .ctrl_i  (ctrl),
    .res_o   (res_d),
    .carry_o (carry_d),
    .ovf_o   (ovf_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      result    <= res_d;
      carry_out <= carry_d;
      ovf_flag  <= ovf_d;
    end
  end

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd0 || op_code == 4'd1) |=> result == $past(opnd_a) + $past(opnd_b)); // R2

  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd2 || op_code == 4'd3) |=> result == $past(opnd_a) - $past(opnd_b)); // R4

  AST_SIGNED_ADD_OVF: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd0 && opnd_a[MSB] != opnd_b[MSB]) |=> !ovf_flag); // R2

  AST_UNSIGNED_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd1 || op_code == 4'd3) |=> !ovf_flag); // R3

  AST_CMP_NARROW: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd10 || op_code == 4'd11) |=> result[MSB:1] == '0); // R7

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_code inside {4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}) |=> result == '0); // R9

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op_code >= 4'd4) |=> (!carry_out && !ovf_flag)); // R10

endmodule

// File: tb/slice_alu_tb_top.sv
module slice_alu_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [3:0]   op_code = '0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slice_alu #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .result    (result),
    .carry_out (carry_out),
    .ovf_flag  (ovf_flag)
  );

  // Reference: returns {carry, ovf, result}
  function automatic logic [W+1:0] ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [3:0] m);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic         c;
    logic         v;
    r = '0; c = 1'b0; v = 1'b0;
    case (m)
      4'd0, 4'd1: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[W-1:0]; c = wide[W];
        if (m == 4'd0) v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'd2, 4'd3: begin
        wide = {1'b0, a} + {1'b0, ~b} + 1;
        r = wide[W-1:0]; c = wide[W];
        if (m == 4'd2) v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~(a | b);
      4'd10: r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      4'd11: r = {{(W-1){1'b0}}, (a < b)};
      default: r = '0;
    endcase
    return {c, v, r};
  endfunction

  task automatic compare(input string tag, input logic [W+1:0] exp);
    checks++;
    if ({carry_out, ovf_flag, result} !== exp) begin
      errors++;
      $display("FAIL %s: got c=%0b v=%0b r=%h, expected c=%0b v=%0b r=%h",
               tag, carry_out, ovf_flag, result, exp[W+1], exp[W], exp[W-1:0]);
    end
  endtask

  // Drive at falling edge, registered at next rising edge, sample at following falling edge.
  task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] m);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_code = m;
    @(negedge clk);
    compare(tag, ref_model(a, b, m));
  endtask

  task automatic t_reset();
    opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h0000_0001; op_code = 4'd0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset clears outputs", '0);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 one-cycle latency after reset", ref_model(32'hFFFF_FFFF, 32'h1, 4'd0));
    rst = 1'b1;
    @(negedge clk);
    compare("R1 mid-run reset", '0);
    rst = 1'b0;
  endtask

  task automatic t_add();
    apply("R2 signed add small",        32'd5, 32'd7, 4'd0);
    apply("R2 signed add pos overflow", 32'h7FFF_FFFF, 32'd1, 4'd0);
    apply("R2 signed add neg overflow", 32'h8000_0000, 32'h8000_0000, 4'd0);
    apply("R2 signed add carry no ovf", 32'hFFFF_FFFF, 32'd1, 4'd0);
    apply("R3 unsigned add carry",      32'hFFFF_FFFF, 32'd1, 4'd1);
    apply("R3 unsigned add no ovf",     32'h7FFF_FFFF, 32'd1, 4'd1);
    for (int i = 0; i < 40; i++) begin
      apply("R2 signed add random",   $urandom, $urandom, 4'd0);
      apply("R3 unsigned add random", $urandom, $urandom, 4'd1);
    end
  endtask

  task automatic t_sub();
    apply("R4 signed sub equal",          32'h1234_5678, 32'h1234_5678, 4'd2);
    apply("R4 signed sub borrow",         32'd3, 32'd9, 4'd2);
    apply("R4 signed sub minus zero",     32'hDEAD_BEEF, 32'd0, 4'd2);
    apply("R4 signed sub min minus one",  32'h8000_0000, 32'd1, 4'd2);
    apply("R4 signed sub max minus min",  32'h7FFF_FFFF, 32'h8000_0000, 4'd2);
    apply("R5 unsigned sub no ovf",       32'h8000_0000, 32'd1, 4'd3);
    apply("R5 unsigned sub borrow",       32'd0, 32'd1, 4'd3);
    for (int i = 0; i < 40; i++) begin
      apply("R4 signed sub random",   $urandom, $urandom, 4'd2);
      apply("R5 unsigned sub random", $urandom, $urandom, 4'd3);
    end
  endtask

  task automatic t_logic();
    for (int m = 4; m < 8; m++) begin
      apply("R6 logic all ones",  32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(m));
      apply("R6 logic pattern",   32'hF0F0_A5A5, 32'h0FF0_5AA5, 4'(m));
      apply("R6 logic zeros",     32'd0, 32'd0, 4'(m));
      for (int i = 0; i < 10; i++)
        apply("R6 R10 logic random", $urandom, $urandom, 4'(m));
    end
  endtask

  task automatic t_compare();
    apply("R7 signed lt min vs max",  32'h8000_0000, 32'h7FFF_FFFF, 4'd10);
    apply("R7 signed lt max vs min",  32'h7FFF_FFFF, 32'h8000_0000, 4'd10);
    apply("R7 signed lt neg vs pos",  32'hFFFF_FFFF, 32'd1, 4'd10);
    apply("R7 signed lt equal",       32'd42, 32'd42, 4'd10);
    apply("R8 unsigned lt min vs max",32'h8000_0000, 32'h7FFF_FFFF, 4'd11);
    apply("R8 unsigned lt max vs min",32'h7FFF_FFFF, 32'h8000_0000, 4'd11);
    apply("R8 unsigned lt 0 vs all1", 32'd0, 32'hFFFF_FFFF, 4'd11);
    apply("R8 unsigned lt equal",     32'd42, 32'd42, 4'd11);
    for (int i = 0; i < 30; i++) begin
      apply("R7 R10 signed lt random", $urandom, $urandom, 4'd10);
      apply("R8 unsigned lt random",   $urandom, $urandom, 4'd11);
    end
  endtask

  task automatic t_unused();
    int codes[6] = '{8, 9, 12, 13, 14, 15};
    foreach (codes[k]) begin
      apply("R9 unused code carry case", 32'hFFFF_FFFF, 32'h0000_0001, 4'(codes[k]));
      apply("R9 unused code ovf case",   32'h7FFF_FFFF, 32'h8000_0000, 4'(codes[k]));
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_compare();
    t_unused();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule